// File: doc/BRIEF.md
# Polarity Inversion Stage with Asymmetry Guard

This stage sits in a stream of signed audio samples and can flip their polarity without tripping over the lopsided two's-complement range. In that range the most negative code has no positive partner. Negating it without protection gives back the same code, which shows up as a full-scale glitch. Before the sign flip, a guard step makes sure the value can be negated safely. The guard has two styles. An offset style takes one LSB off every strictly positive result. A clamp style changes only the single most negative code.

Each accepted sample produces one registered result exactly one clock later. The guard mode and the invert control are sampled together with the sample in the same cycle. When no sample is offered, the output sample keeps its last value and the output strobe stays low. The sample width is a parameter and defaults to 24 bits.

Top module: `pol_guard_stage`

## Requirements
- R1: In any cycle with reset (`rst_n` low) asserted at the clock edge, `out_valid` becomes 0 and `out_sample` becomes 0.
- R2: A sample presented with `in_valid` high at a clock edge appears on `out_sample`, with `out_valid` high, right after that edge. This gives a latency of exactly one clock. Back-to-back samples are accepted every cycle.
- R3: At an edge where `in_valid` is low, `out_valid` goes to 0 and `out_sample` keeps its previous value. The values on `in_sample`, `guard_mode` and `invert` are ignored.
- R4: Offset mode (`guard_mode` = 2'b01) with `invert` = 0 handles samples as follows. A sample strictly greater than zero leaves reduced by one LSB. Zero and negative samples, the most negative code among them, pass unchanged. The sequence -2, 0, 1, 0, 2, 3 becomes -2, 0, 0, 0, 1, 2.
- R5: Clamp mode (`guard_mode` = 2'b10) with `invert` = 0 turns the most negative code -2^(W-1) into -(2^(W-1)-1). Every other code passes unchanged.
- R6: With the guard off (`guard_mode` = 2'b00, or the spare code 2'b11, which behaves the same) and `invert` = 0, every sample passes bit-exact.
- R7: Clamp mode with `invert` = 1 gives the negation of the clamped value. The most negative input gives 2^(W-1)-1, and the output is never -2^(W-1).
- R8: Offset mode with `invert` = 1 applies the offset to the inverted result. A negative input x gives -x-1, and zero or a positive input x gives -x. The most negative input therefore gives 2^(W-1)-1, and the output is never -2^(W-1).
- R9: With the guard off and `invert` = 1, the output is -x modulo 2^W. The most negative code maps to itself, which is the unguarded wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | W | Signed input sample, two's complement |
| guard_mode | input | 2 | 00 off, 01 offset, 10 clamp, 11 off |
| invert | input | 1 | Flip polarity after the guard |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_sample | output | W | Signed processed sample, held while idle |

## Verification
Some properties are checked by assertions on every cycle:
- the one-clock strobe relation;
- the hold of the output sample while idle;
- the one-LSB drop on positive samples in non-inverted offset mode;
- bit-exact bypass;
- clamp mode passing every code other than the most negative one;
- the absence of the most negative code at the output whenever a guard and inversion are both active.

The exact inverted values need the bench's scenarios, which compare every result against an independent model. These include the most negative code mapping to the largest positive one, the wrap with the guard off, and the full output of the document's short sequence. The scenarios also show that idle-cycle inputs are ignored and that the reset state is correct.

// File: rtl/pol_guard_pkg.sv
// Package: shared mode encoding for the polarity guard stage.
// Assumes: two mode bits; the spare code behaves as guard off.
package pol_guard_pkg;
    typedef enum logic [1:0] {
        GM_OFF     = 2'b00,
        GM_OFFSET  = 2'b01,
        GM_CLAMP   = 2'b10,
        GM_OFF_ALT = 2'b11
    } guard_mode_e;
endpackage

// File: rtl/pol_guard_unit.sv
// Module: pol_guard_unit
// Makes a signed sample safe for the later sign flip.
// Offset style: without inversion, positive samples drop one LSB. With
// inversion, negative samples rise one LSB, so that after negation the
// positive results are the ones lowered.
// Clamp style: only the most negative code is moved up by one.
// Assumes: purely combinational; the caller registers the result.
module pol_guard_unit #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] x,
    input  logic [1:0]          mode,
    input  logic                invert,
    output logic signed [W-1:0] g
);
    import pol_guard_pkg::*;

    localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    guard_mode_e mode_e;
    assign mode_e = guard_mode_e'(mode);

    // Purpose: select the guard correction for the current mode.
    always_comb begin
        g = x;
        case (mode_e)
            GM_OFFSET: begin
                if (invert) begin
                    if (x < 0) g = x + ONE;
                end else begin
                    if (x > 0) g = x - ONE;
                end
            end
            GM_CLAMP: begin
                if (x == MIN_CODE) g = MIN_CODE + ONE;
            end
            default: g = x;
        endcase
    end
endmodule

// File: rtl/pol_invert_unit.sv
// Module: pol_invert_unit
// Optionally negates the guarded value (two's complement, W bits).
// Assumes: the guard has already removed the most negative code whenever
// a guard is active; with the guard off, the wrap is left as is.
module pol_invert_unit #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] g,
    input  logic                invert,
    output logic signed [W-1:0] y
);
    // Purpose: choose the original or the negated value.
    always_comb begin
        y = invert ? -g : g;
    end
endmodule

// File: rtl/pol_out_reg.sv
// Module: pol_out_reg
// Single output register stage: captures data on a valid strobe, holds it
// otherwise, and forwards the strobe with one clock of delay.
// Assumes: synchronous active-low reset.
module pol_out_reg #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d_valid,
    input  logic signed [W-1:0] d,
    output logic                q_valid,
    output logic signed [W-1:0] q
);
    // Purpose: delay the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Purpose: capture data on a strobe and hold it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (d_valid) q <= d;
    end
endmodule

// File: rtl/pol_guard_stage.sv
// Module: pol_guard_stage (top)
// Streaming polarity stage with an asymmetry guard: guard, then optional
// negation, then one register. Latency is one clock.
// Assumes: guard_mode and invert are sampled with in_sample.
module pol_guard_stage #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    input  logic [1:0]          guard_mode,
    input  logic                invert,
    output logic                out_valid,
    output logic signed [W-1:0] out_sample
);
    localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic signed [W-1:0] guarded;
    logic signed [W-1:0] flipped;

    pol_guard_unit #(.W(W)) u_guard (
        .x      (in_sample),
        .mode   (guard_mode),
        .invert (invert),
        .g      (guarded)
    );

    pol_invert_unit #(.W(W)) u_inv (
        .g      (guarded),
        .invert (invert),
        .y      (flipped)
    );

    pol_out_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d       (flipped),
        .q_valid (out_valid),
        .q       (out_sample)
    );

    // R2: strobe follows one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3: idle cycle drops the strobe and holds the sample
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample)));

    // R4: offset mode without inversion lowers positives by one
    a_r4_offset_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && guard_mode == 2'b01 && !invert && in_sample > 0)
        |=> ((out_sample + ONE) == $past(in_sample)));

    // R5: clamp mode leaves every non-extreme code alone
    a_r5_clamp_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && guard_mode == 2'b10 && !invert && in_sample != MIN_CODE)
        |=> (out_sample == $past(in_sample)));

    // R6: bypass is bit-exact
    a_r6_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !invert && (guard_mode == 2'b00 || guard_mode == 2'b11))
        |=> (out_sample == $past(in_sample)));

    // R7, R8: guarded inversion never produces the most negative code
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && invert && (guard_mode == 2'b01 || guard_mode == 2'b10))
        |=> (out_sample != MIN_CODE));
endmodule

// File: tb/pol_guard_stage_test.sv
module pol_guard_stage_test;
    localparam int W = 24;
    localparam int CLK_PERIOD = 10;
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    typedef struct {
        logic signed [W-1:0] exp;
        string               tag;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic [1:0]          guard_mode = 2'b00;
    logic                invert = 1'b0;
    logic                out_valid;
    logic signed [W-1:0] out_sample;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb[$];

    pol_guard_stage #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .guard_mode (guard_mode),
        .invert     (invert),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference written from the requirements, case by case
    function automatic logic signed [W-1:0] model(logic signed [W-1:0] x,
                                                   logic [1:0] m, logic inv);
        logic signed [W-1:0] r;
        case (m)
            2'b01: begin
                if (!inv) r = (x > 0) ? x - 1 : x;      // R4
                else      r = (x < 0) ? -x - 1 : -x;    // R8
            end
            2'b10: begin
                if (!inv) r = (x == MINV) ? MINV + 1 : x; // R5
                else      r = (x == MINV) ? MAXV : -x;    // R7
            end
            default: r = inv ? -x : x;                  // R6, R9
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic signed [W-1:0] act,
                         logic signed [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(logic signed [W-1:0] x, logic [1:0] m, logic inv,
                        string tag);
        item_t it;
        @(negedge clk);
        in_valid   = 1'b1;
        in_sample  = x;
        guard_mode = m;
        invert     = inv;
        it.exp = model(x, m, inv);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid   = 1'b0;
        in_sample  = $urandom;
        guard_mode = 2'($urandom);
        invert     = 1'($urandom);
    endtask

    // Monitor: pop one expected item per output strobe
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", out_sample, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_sample == it.exp, it.tag, out_sample, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", {{(W-1){1'b0}}, out_valid}, '0);
        check(out_sample == '0, "R1 out_sample in reset", out_sample, '0);
        rst_n = 1'b1;

        // R4 short sequence, back to back (also R2)
        send(-2, 2'b01, 0, "R4 seq -2");
        send(0,  2'b01, 0, "R4 seq 0");
        send(1,  2'b01, 0, "R4 seq 1");
        send(0,  2'b01, 0, "R4 seq 0b");
        send(2,  2'b01, 0, "R4 seq 2");
        send(3,  2'b01, 0, "R4 seq 3");
        send(MAXV, 2'b01, 0, "R4 max");
        send(MINV, 2'b01, 0, "R4 min unchanged");
        // R5 clamp
        send(MINV,     2'b10, 0, "R5 min clamped");
        send(MINV + 1, 2'b10, 0, "R5 min+1 kept");
        send(MAXV,     2'b10, 0, "R5 max kept");
        send(0,        2'b10, 0, "R5 zero kept");
        // R6 bypass with both off codes
        send(MINV, 2'b00, 0, "R6 min bypass");
        send(MAXV, 2'b11, 0, "R6 max spare code");
        send(-1,   2'b11, 0, "R6 -1 spare code");
        // R7 clamp with inversion
        send(MINV, 2'b10, 1, "R7 min to max");
        send(MAXV, 2'b10, 1, "R7 max negated");
        send(5,    2'b10, 1, "R7 five");
        send(0,    2'b10, 1, "R7 zero");
        // R8 offset with inversion
        send(MINV, 2'b01, 1, "R8 min to max");
        send(-1,   2'b01, 1, "R8 -1 to 0");
        send(0,    2'b01, 1, "R8 zero");
        send(3,    2'b01, 1, "R8 three");
        send(MAXV, 2'b01, 1, "R8 max");
        // R9 unguarded inversion
        send(MINV, 2'b00, 1, "R9 min wraps");
        send(7,    2'b11, 1, "R9 seven");

        // R3 hold while idle, inputs ignored
        send(123, 2'b00, 0, "R3 hold source");
        idle();
        for (int k = 0; k < 3; k++) begin
            idle();
            check(out_valid == 1'b0, "R3 out_valid idle", {{(W-1){1'b0}}, out_valid}, '0);
            check(out_sample == 123, "R3 sample held", out_sample, 123);
        end

        // Random codes with random bubbles over every mode/invert pair
        for (int n = 0; n < 800; n++) begin
            send($urandom, 2'($urandom), 1'($urandom), "R2 random");
            if ($urandom_range(3) == 0) idle();
        end

        idle();
        idle();
        idle();
        check(sb.size() == 0, "R2 results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule